// File: doc/BRIEF.md
# Width-Converting FIFO with Selectable Lane Order

This block is a single-clock FIFO whose write and read ports differ in width by a power-of-two ratio. A narrow write port combined with a wide read port packs several narrow lanes into one wide word. A wide write port combined with a narrow read port splits each wide word into lanes, one lane per read. One parameter sets which end of the wide word holds the lane that is earliest in time. When `LANE_MSB_FIRST` is 1, the earliest lane is in the top bits. When it is 0, the earliest lane is in the bottom bits.

The read port is first-word-fall-through. Whenever `empty` is low, the head entry is already on `dout`, and a read shows the next entry after the same clock edge. The write side offers `full`, `almost_full`, a threshold flag `prog_full` and a one-cycle `overflow` pulse. The read side offers `empty` and a one-cycle `underflow` pulse. Storage is `WIDE_DEPTH` wide words. All write-side flags count in units of the write width.

Top module: `asym_fifo`

## Requirements
- R1: With `LANE_MSB_FIRST`=1 and packing, the first lane written appears in `dout[RD_W-1 -: WR_W]` and the last one appears in `dout[WR_W-1:0]`.
- R2: With `LANE_MSB_FIRST`=0 and packing, the first lane written appears in `dout[WR_W-1:0]` and the last one appears in the top lane.
- R3: When unpacking, successive reads return the lanes of a written word. With `LANE_MSB_FIRST`=1 the order runs from the top lane down. With `LANE_MSB_FIRST`=0 it runs from the bottom lane up.
- R4: When packing, `empty` stays high until every lane of a wide word has been written. A partially assembled word is never readable.
- R5: While `empty` is low, `dout` holds the head entry. When a read is accepted at an edge, the following entry is on `dout` right after that edge. With no read, `dout` holds its value.
- R6: `full` and `almost_full` count in write-width entries, out of a capacity of `WIDE_DEPTH*RATIO` lanes (packing) or `WIDE_DEPTH` words (unpacking). `almost_full` means exactly one more write fits. When unpacking, a wide entry is released only once its last lane has been read.
- R7: `prog_full` is high exactly when the stored count in write-width units is at least `PROG_TH`.
- R8: A write while `full` is dropped and leaves the contents unchanged. `overflow` is high for the one cycle after the rejected write.
- R9: A read while `empty` is dropped and leaves the pointers unchanged. `underflow` is high for the one cycle after the rejected read.
- R10: Synchronous active-high `rst` empties the FIFO, lowers `full`, `almost_full`, `prog_full`, `overflow` and `underflow`, and forces `dout` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | WR_W | Write data |
| wr_en | input | 1 | Write request |
| full | output | 1 | No write can be accepted |
| almost_full | output | 1 | Exactly one more write fits |
| prog_full | output | 1 | Write-unit count at or above `PROG_TH` |
| overflow | output | 1 | The write in the previous cycle was rejected |
| dout | output | RD_W | Head entry, zero while empty |
| rd_en | input | 1 | Read request |
| empty | output | 1 | No complete read entry available |
| underflow | output | 1 | The read in the previous cycle was rejected |

## Verification
The flags and `dout` are combinational functions of the pointers, so they change one clock edge after the write or read that moves a pointer. `overflow` and `underflow` are registered, so they also appear one edge after the rejected request and clear on the edge after that. The bench drives inputs on the falling edge, lets exactly one rising edge pass, and samples on the next falling edge. In that way every check sees the state that the single preceding rising edge produced. Four instances run side by side: packing and unpacking, each in both lane orders. This lets each order be compared on the same stimulus.

// File: rtl/asym_fifo.sv
module asym_fifo #(
  parameter int WR_W           = 8,
  parameter int RD_W           = 32,
  parameter int WIDE_DEPTH     = 16,
  parameter int PROG_TH        = 40,
  parameter bit LANE_MSB_FIRST = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [WR_W-1:0] din,
  input  logic            wr_en,
  output logic            full,
  output logic            almost_full,
  output logic            prog_full,
  output logic            overflow,
  output logic [RD_W-1:0] dout,
  input  logic            rd_en,
  output logic            empty,
  output logic            underflow
);
  localparam bit PACK  = RD_W > WR_W;
  localparam int LW    = PACK ? WR_W : RD_W;
  localparam int WW    = PACK ? RD_W : WR_W;
  localparam int RATIO = WW / LW;
  localparam int LG    = $clog2(RATIO);
  localparam int LANES = WIDE_DEPTH * RATIO;
  localparam int IW    = $clog2(LANES);
  localparam int AW    = IW + 1;
  localparam int QW    = AW - LG;
  localparam int WCAP  = PACK ? LANES : WIDE_DEPTH;
  localparam int WSTEP = PACK ? 1 : RATIO;
  localparam int RSTEP = PACK ? RATIO : 1;

  logic [LW-1:0] mem [LANES];
  logic [AW-1:0] wp, rp;
  logic [RD_W-1:0] rword;

  wire [AW-1:0] lane_used = wp - rp;
  wire [QW-1:0] word_diff = wp[AW-1:LG] - rp[AW-1:LG];
  wire [AW-1:0] word_used = AW'(word_diff);
  wire [AW-1:0] wcnt = PACK ? lane_used : word_used;
  wire [AW-1:0] rcnt = PACK ? word_used : lane_used;
  wire [IW-1:0] wa = wp[IW-1:0];
  wire [IW-1:0] ra = rp[IW-1:0];

  assign full        = wcnt == AW'(WCAP);
  assign almost_full = wcnt == AW'(WCAP - 1);
  assign prog_full   = wcnt >= AW'(PROG_TH);
  assign empty       = rcnt == '0;
  assign dout        = empty ? '0 : rword;

  wire wr_ok = wr_en & ~full;
  wire rd_ok = rd_en & ~empty;

  function automatic int lane_pos(int k);
    return LANE_MSB_FIRST ? (RATIO - 1 - k) * LW : k * LW;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wp        <= '0;
      rp        <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (wr_ok) wp <= wp + AW'(WSTEP);
      if (rd_ok) rp <= rp + AW'(RSTEP);
      overflow  <= wr_en & full;
      underflow <= rd_en & empty;
    end
  end

  generate
    if (PACK) begin : g_pack
      always_ff @(posedge clk)
        if (wr_ok) mem[wa] <= din;
      always_comb begin
        rword = '0;
        for (int k = 0; k < RATIO; k++)
          rword[lane_pos(k) +: LW] = mem[ra + IW'(k)];
      end
    end else begin : g_unpack
      always_ff @(posedge clk)
        if (wr_ok)
          for (int k = 0; k < RATIO; k++)
            mem[wa + IW'(k)] <= din[lane_pos(k) +: LW];
      assign rword = mem[ra];
    end
  endgenerate

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en) |=> (full && $stable(wp))); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty && !wr_en) |=> (empty && $stable(rp))); // R9
  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!empty && !rd_en) |=> $stable(dout)); // R5
  AST_ALMOST_TO_FULL: assert property (@(posedge clk) disable iff (rst)
    (almost_full && wr_en && !rd_en) |=> full); // R6
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(full && empty)); // R6
  AST_FULL_IMPLIES_PROG: assert property (@(posedge clk) disable iff (rst)
    full |-> prog_full); // R7
endmodule

// File: tb/sim_asym_fifo.sv
`timescale 1ns/1ps
module sim_asym_fifo;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [7:0]  p_din = '0;
  logic        p_wr = 1'b0, p_rd = 1'b0;
  logic [31:0] u_din = '0;
  logic        u_wr = 1'b0, u_rd = 1'b0;

  logic [31:0] p_dout [2];
  logic        p_full [2], p_af [2], p_pf [2], p_ovf [2], p_emp [2], p_udf [2];
  logic [7:0]  u_dout [2];
  logic        u_full [2], u_af [2], u_pf [2], u_ovf [2], u_emp [2], u_udf [2];

  int checks = 0;
  int fails  = 0;

  asym_fifo #(.WR_W(8), .RD_W(32), .WIDE_DEPTH(4), .PROG_TH(8), .LANE_MSB_FIRST(1'b1)) u0 (
    .clk(clk), .rst(rst), .din(p_din), .wr_en(p_wr), .full(p_full[0]), .almost_full(p_af[0]),
    .prog_full(p_pf[0]), .overflow(p_ovf[0]), .dout(p_dout[0]), .rd_en(p_rd),
    .empty(p_emp[0]), .underflow(p_udf[0]));
  asym_fifo #(.WR_W(8), .RD_W(32), .WIDE_DEPTH(4), .PROG_TH(8), .LANE_MSB_FIRST(1'b0)) u1 (
    .clk(clk), .rst(rst), .din(p_din), .wr_en(p_wr), .full(p_full[1]), .almost_full(p_af[1]),
    .prog_full(p_pf[1]), .overflow(p_ovf[1]), .dout(p_dout[1]), .rd_en(p_rd),
    .empty(p_emp[1]), .underflow(p_udf[1]));
  asym_fifo #(.WR_W(32), .RD_W(8), .WIDE_DEPTH(4), .PROG_TH(3), .LANE_MSB_FIRST(1'b1)) u2 (
    .clk(clk), .rst(rst), .din(u_din), .wr_en(u_wr), .full(u_full[0]), .almost_full(u_af[0]),
    .prog_full(u_pf[0]), .overflow(u_ovf[0]), .dout(u_dout[0]), .rd_en(u_rd),
    .empty(u_emp[0]), .underflow(u_udf[0]));
  asym_fifo #(.WR_W(32), .RD_W(8), .WIDE_DEPTH(4), .PROG_TH(3), .LANE_MSB_FIRST(1'b0)) u3 (
    .clk(clk), .rst(rst), .din(u_din), .wr_en(u_wr), .full(u_full[1]), .almost_full(u_af[1]),
    .prog_full(u_pf[1]), .overflow(u_ovf[1]), .dout(u_dout[1]), .rd_en(u_rd),
    .empty(u_emp[1]), .underflow(u_udf[1]));

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pwrite(input logic [7:0] b);
    p_din = b; p_wr = 1'b1;
    step();
    p_wr = 1'b0;
  endtask

  task automatic pread();
    p_rd = 1'b1;
    step();
    p_rd = 1'b0;
  endtask

  task automatic uwrite(input logic [31:0] w);
    u_din = w; u_wr = 1'b1;
    step();
    u_wr = 1'b0;
  endtask

  task automatic uread();
    u_rd = 1'b1;
    step();
    u_rd = 1'b0;
  endtask

  task automatic test_reset();
    chk("R10", "pack empty", p_emp[0], 1);
    chk("R10", "pack dout", p_dout[0], 0);
    chk("R10", "pack flags", {p_full[0], p_af[0], p_pf[0], p_ovf[0], p_udf[0]}, 0);
    chk("R10", "unpack empty", u_emp[1], 1);
    chk("R10", "unpack dout", u_dout[1], 0);
    chk("R10", "unpack flags", {u_full[1], u_af[1], u_pf[1], u_ovf[1], u_udf[1]}, 0);
  endtask

  task automatic test_pack_order();
    logic [7:0] b [4] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
    for (int i = 0; i < 4; i++) begin
      pwrite(b[i]);
      if (i < 3) chk("R4", "partial word hidden", {p_emp[0], p_emp[1]}, 2'b11);
    end
    chk("R4", "complete word visible", {p_emp[0], p_emp[1]}, 2'b00);
    chk("R1", "msb-first pack", p_dout[0], 32'hA1B2C3D4);
    chk("R2", "lsb-first pack", p_dout[1], 32'hD4C3B2A1);
    pread();
    chk("R5", "empty after single read", p_emp[0], 1);
  endtask

  task automatic test_fwft();
    for (int i = 1; i <= 8; i++) pwrite(8'(i));
    chk("R5", "head word", p_dout[0], 32'h01020304);
    step();
    chk("R5", "hold without read", p_dout[0], 32'h01020304);
    pread();
    chk("R5", "next word after read", p_dout[0], 32'h05060708);
    chk("R2", "next word lsb-first", p_dout[1], 32'h08070605);
    pread();
    chk("R5", "drained", p_emp[0], 1);
  endtask

  task automatic test_pack_full();
    for (int i = 0; i < 16; i++) begin
      pwrite(8'(8'h10 + i));
      if (i == 6)  chk("R7", "prog_full below threshold", p_pf[0], 0);
      if (i == 7)  chk("R7", "prog_full at threshold", p_pf[0], 1);
      if (i == 14) chk("R6", "almost_full/full at 15 lanes", {p_af[0], p_full[0]}, 2'b10);
    end
    chk("R6", "almost_full/full at 16 lanes", {p_af[0], p_full[0]}, 2'b01);
    chk("R8", "no overflow yet", p_ovf[0], 0);
    pwrite(8'hFF);
    chk("R8", "overflow pulse", p_ovf[0], 1);
    chk("R8", "still full", p_full[0], 1);
    step();
    chk("R8", "overflow clears", p_ovf[0], 0);
    for (int j = 0; j < 4; j++) begin
      chk("R8", "contents intact", p_dout[0],
          {8'(8'h10 + 4*j), 8'(8'h11 + 4*j), 8'(8'h12 + 4*j), 8'(8'h13 + 4*j)});
      pread();
    end
    chk("R8", "empty after drain", p_emp[0], 1);
  endtask

  task automatic test_underflow();
    pread();
    chk("R9", "underflow pulse", p_udf[0], 1);
    chk("R9", "still empty", p_emp[0], 1);
    step();
    chk("R9", "underflow clears", p_udf[0], 0);
    pwrite(8'h5A); pwrite(8'h5B); pwrite(8'h5C); pwrite(8'h5D);
    chk("R9", "pointers intact", p_dout[0], 32'h5A5B5C5D);
    pread();
  endtask

  task automatic test_unpack_order();
    logic [7:0] be [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
    uwrite(32'h11223344);
    u_rd = 1'b1;
    for (int i = 0; i < 4; i++) begin
      chk("R3", "msb-first unpack", u_dout[0], be[i]);
      chk("R3", "lsb-first unpack", u_dout[1], be[3-i]);
      step();
    end
    u_rd = 1'b0;
    chk("R3", "empty after lanes", u_emp[0], 1);
  endtask

  task automatic test_unpack_free();
    for (int i = 0; i < 4; i++) begin
      uwrite(32'hA0A1A2A3 + 32'h10101010 * i);
      if (i == 1) chk("R7", "prog_full below threshold", u_pf[0], 0);
      if (i == 2) begin
        chk("R7", "prog_full at threshold", u_pf[0], 1);
        chk("R6", "almost_full at 3 words", {u_af[0], u_full[0]}, 2'b10);
      end
    end
    chk("R6", "full at 4 words", u_full[0], 1);
    for (int i = 0; i < 3; i++) uread();
    chk("R6", "entry held until last lane", u_full[0], 1);
    uread();
    chk("R6", "entry released", {u_af[0], u_full[0]}, 2'b10);
    chk("R3", "next word first lane", u_dout[0], 8'hB0);
    u_rd = 1'b1;
    for (int i = 0; i < 12; i++) step();
    u_rd = 1'b0;
    chk("R6", "unpack drained", u_emp[0], 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_pack_order();
    test_fwft();
    test_pack_full();
    test_underflow();
    test_unpack_order();
    test_unpack_free();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule